// File: doc/BRIEF.md
# Lucas-Lehmer Mersenne Primality Tester

This block decides whether the Mersenne number M = 2^q − 1 is prime for an exponent q from 3 up to a parameter limit (61 by default). A pulse on `start` samples `q`. The block then runs the Lucas-Lehmer recurrence. The residue begins at 4, and every round it is squared, reduced modulo M, and lowered by two. After the fixed number of rounds, a zero residue means M is prime.

Squaring uses a shift-add multiplier that adds one partial product per cycle. Reduction needs no divider: it adds the bits of the product above position q to the bits below, and does this twice. A controller steps through the rounds and tells the datapath what to do through a small struct of strobes. A thin top module wires the two together.

Exponents below 3 or above the limit are refused at once, and no run begins.

Top module: `llTesterTop`

## Requirements
- R1: After reset, `busy`, `done`, `isPrime` and `badQ` are all 0.
- R2: A `start` pulse while idle with 3 ≤ `q` ≤ QMAX makes `busy` 1 from the next cycle until the run ends.
- R3: The verdict is computed as follows. The seed is 4. The recurrence v ← (v² − 2) mod (2^q − 1) is applied exactly q − 2 times. `isPrime` is 1 exactly when the final residue is 0. For q ≤ 61 this gives 1 only for q in {3, 5, 7, 13, 17, 19, 31, 61}.
- R4: `done` is high for exactly one cycle, and `busy` is 0 in that cycle. This happens (q − 2)(q + 1) + 1 cycles after the clock edge that sampled `start`.
- R5: A `start` while idle with `q` < 3 or `q` > QMAX makes `badQ` high for exactly the next cycle. `busy` stays 0 and no `done` follows.
- R6: A `start` while `busy` is 1 is ignored. The running test keeps its verdict and its latency, and `badQ` stays 0.
- R7: `isPrime` keeps its value from one `done` until the next `done`, including through a later run.
- R8: After every reduction step, the residue is below 2^q − 1. A reduced value equal to 2^q − 1 becomes 0. When the reduced square is 0 or 1, subtracting two wraps modulo 2^q − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test with the exponent on `q` |
| q | input | QW (6) | Exponent of the Mersenne number |
| busy | output | 1 | A test is in progress |
| done | output | 1 | One-cycle completion pulse |
| isPrime | output | 1 | Verdict of the most recent completed test |
| badQ | output | 1 | One-cycle pulse: exponent refused |

## Verification
The assertions assume that `q` is only meaningful in the cycle when `start` is sampled while idle. They also assume the datapath only sees widths at least 3, so that q − 2 rounds is a positive count and the wrap by 2^q − 1 − 2 cannot underflow. The stimulus drives `start` for one cycle, on the falling edge. It sends out-of-range exponents only to confirm they are refused. It raises `start` again while a run is active only to show that this pulse is ignored. The sweep covers every legal exponent from 3 to 61, and the expected verdict for each comes from a wide-integer recurrence in the bench.

// File: rtl/llPkg.sv
package llPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_FOLD,
    ST_FIN
  } llState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic load;     // seed the residue and clear the product
    logic mulStep;  // add one partial product
    logic fold;     // reduce, subtract two, store residue
  } llStrobe_t;

endpackage

// File: rtl/llDatapath.sv
module llDatapath #(
  parameter int QMAX = 61,
  parameter int QW   = $clog2(QMAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  llPkg::llStrobe_t strobe,
  input  logic [QW-1:0]    width,
  input  logic [QW-1:0]    bitIdx,
  output logic             resZero
);
  localparam int W  = QMAX;
  localparam int PW = 2 * QMAX;

  logic [W-1:0]  resid;
  logic [PW-1:0] prod;
  logic [W-1:0]  modMask;
  logic [PW-1:0] wideMask;
  logic [PW-1:0] partial;
  logic [PW-1:0] sum1;
  logic [W-1:0]  sum2;
  logic [W-1:0]  sqMod;
  logic [W-1:0]  nextResid;

  always_comb begin
    modMask  = ~({W{1'b1}} << width);
    wideMask = {{(PW - W){1'b0}}, modMask};
    partial  = resid[bitIdx] ? ({{(PW - W){1'b0}}, resid} << bitIdx) : '0;
    // first fold: high part onto low part
    sum1     = (prod & wideMask) + (prod >> width);
    // second fold absorbs the single carry left over
    sum2     = W'((sum1 & wideMask) + (sum1 >> width));
    sqMod    = (sum2 == modMask) ? '0 : sum2;
    if (sqMod >= W'(2)) nextResid = sqMod - W'(2);
    else                nextResid = sqMod + modMask - W'(2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resid <= '0;
      prod  <= '0;
    end else if (strobe.load) begin
      resid <= W'(4);
      prod  <= '0;
    end else if (strobe.mulStep) begin
      prod <= prod + partial;
    end else if (strobe.fold) begin
      resid <= nextResid;
      prod  <= '0;
    end
  end

  assign resZero = (resid == '0);

  // R3: seed is four after a load
  a_r3_seed: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (resid == W'(4)));

  // R8: stored residue is fully reduced below the modulus
  a_r8_residue_reduced: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fold |=> (resid < $past(modMask)));

  // R8: product register is cleared after every fold
  a_r8_prod_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fold |=> (prod == '0));

endmodule

// File: rtl/llControl.sv
module llControl #(
  parameter int QMAX = 61,
  parameter int QW   = $clog2(QMAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [QW-1:0]    q,
  input  logic             resZero,
  output llPkg::llStrobe_t strobe,
  output logic [QW-1:0]    width,
  output logic [QW-1:0]    bitIdx,
  output logic             busy,
  output logic             done,
  output logic             isPrime,
  output logic             badQ
);
  import llPkg::*;

  llState_t      state;
  logic [QW-1:0] qReg;
  logic [QW-1:0] iterCnt;
  logic          qOk;
  logic          doneReg;
  logic          badReg;
  logic          primeReg;

  assign qOk = (q >= QW'(3)) && (q <= QW'(QMAX));

  always_comb begin
    strobe.load    = (state == ST_IDLE) && start && qOk;
    strobe.mulStep = (state == ST_MUL);
    strobe.fold    = (state == ST_FOLD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      qReg     <= QW'(3);
      bitIdx   <= '0;
      iterCnt  <= '0;
      doneReg  <= 1'b0;
      badReg   <= 1'b0;
      primeReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      badReg  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (qOk) begin
              qReg    <= q;
              bitIdx  <= '0;
              iterCnt <= '0;
              state   <= ST_MUL;
            end else begin
              badReg <= 1'b1;
            end
          end
        end
        ST_MUL: begin
          if (bitIdx == qReg - QW'(1)) begin
            bitIdx <= '0;
            state  <= ST_FOLD;
          end else begin
            bitIdx <= bitIdx + QW'(1);
          end
        end
        ST_FOLD: begin
          iterCnt <= iterCnt + QW'(1);
          if (iterCnt + QW'(1) == qReg - QW'(2)) state <= ST_FIN;
          else                                   state <= ST_MUL;
        end
        default: begin
          doneReg  <= 1'b1;
          primeReg <= resZero;
          state    <= ST_IDLE;
        end
      endcase
    end
  end

  assign width   = qReg;
  assign busy    = (state != ST_IDLE);
  assign done    = doneReg;
  assign isPrime = primeReg;
  assign badQ    = badReg;

  // R4: done lasts one cycle and never overlaps busy
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5: refused exponent raises badQ and starts nothing
  a_r5_reject: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && start && !qOk) |=> (badQ && !busy));

  // R6: round counter never passes the required count
  a_r6_iter_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (iterCnt <= qReg - QW'(2)));

  // R7: verdict changes only together with done
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(isPrime));

endmodule

// File: rtl/llTesterTop.sv
module llTesterTop #(
  parameter int QMAX = 61,
  parameter int QW   = $clog2(QMAX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [QW-1:0] q,
  output logic          busy,
  output logic          done,
  output logic          isPrime,
  output logic          badQ
);
  llPkg::llStrobe_t strobe;
  logic [QW-1:0]    width;
  logic [QW-1:0]    bitIdx;
  logic             resZero;

  llControl #(.QMAX(QMAX), .QW(QW)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .q(q), .resZero(resZero),
    .strobe(strobe), .width(width), .bitIdx(bitIdx),
    .busy(busy), .done(done), .isPrime(isPrime), .badQ(badQ)
  );

  llDatapath #(.QMAX(QMAX), .QW(QW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .width(width),
    .bitIdx(bitIdx), .resZero(resZero)
  );

endmodule

// File: tb/llTesterTop_tb_top.sv
module llTesterTop_tb_top;
  localparam int QMAX = 61;
  localparam int QW   = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [QW-1:0] qIn = '0;
  logic          busy, done, isPrime, badQ;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  llTesterTop #(.QMAX(QMAX), .QW(QW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .q(qIn),
    .busy(busy), .done(done), .isPrime(isPrime), .badQ(badQ)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit llRef(input int qv);
    logic [127:0] m, v;
    m = (128'd1 << qv) - 128'd1;
    v = 128'd4;
    for (int i = 0; i < qv - 2; i++) begin
      v = (v * v) % m;
      v = (v + m - 128'd2) % m;
    end
    return (v == 128'd0);
  endfunction

  // pulse start; returns at the falling edge after the sampling edge
  task automatic pulseStart(input int qv);
    @(negedge clk);
    qIn = QW'(qv);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runTest(input int qv, input bit inject);
    int n = 0;
    bit sawBad = 0;
    int expLat = (qv - 2) * (qv + 1) + 1;
    bit expPrime = llRef(qv);
    pulseStart(qv);
    check(busy == 1'b1, "R2", $sformatf("busy after start q=%0d", qv), busy, 1);
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (badQ) sawBad = 1;
      if (inject && n == 20) begin start = 1'b1; qIn = QW'(5); end
      else if (inject && n == 21) begin start = 1'b0; qIn = QW'(2); end
      else if (inject && n == 22) begin start = 1'b1; end
      else if (inject && n == 23) begin start = 1'b0; end
    end
    check(expLat == n, "R4", $sformatf("latency q=%0d", qv), n, expLat);
    check(isPrime == expPrime, "R3 R8", $sformatf("verdict q=%0d", qv), isPrime, expPrime);
    check(busy == 1'b0, "R4", $sformatf("busy with done q=%0d", qv), busy, 0);
    if (inject) check(!sawBad, "R6", "badQ during busy", sawBad, 0);
    @(negedge clk);
    check(done == 1'b0, "R4", $sformatf("done width q=%0d", qv), done, 0);
  endtask

  task automatic rejectTest(input int qv);
    pulseStart(qv);
    check(badQ == 1'b1, "R5", $sformatf("badQ q=%0d", qv), badQ, 1);
    check(busy == 1'b0, "R5", $sformatf("busy after refuse q=%0d", qv), busy, 0);
    @(negedge clk);
    check(badQ == 1'b0 && done == 1'b0, "R5",
          $sformatf("badQ/done after refuse q=%0d", qv), {badQ, done}, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R4 watchdog actual=timeout(%0d) expected=finish(%0d)", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", "busy at reset", busy, 0);
    check(done == 1'b0, "R1", "done at reset", done, 0);
    check(isPrime == 1'b0, "R1", "isPrime at reset", isPrime, 0);
    check(badQ == 1'b0, "R1", "badQ at reset", badQ, 0);
    rstN = 1'b1;

    // R5: exponents outside the legal range
    rejectTest(0);
    rejectTest(1);
    rejectTest(2);
    rejectTest(62);
    rejectTest(63);

    // R2 R3 R4 R8: sweep every legal exponent
    for (int qv = 3; qv <= QMAX; qv++) runTest(qv, 1'b0);

    // R7: verdict held after a prime result, through the next run
    runTest(7, 1'b0);
    repeat (5) @(negedge clk);
    check(isPrime == 1'b1, "R7", "hold after done", isPrime, 1);
    pulseStart(11);
    repeat (30) @(negedge clk);
    check(isPrime == 1'b1, "R7", "hold during next run", isPrime, 1);
    while (!done) @(negedge clk);
    check(isPrime == 1'b0, "R7", "updated at done q=11", isPrime, 0);

    // R6: starts during a run are ignored
    runTest(11, 1'b1);
    runTest(13, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule